// File: doc/BRIEF.md
# GPIO Interrupt Channel Multiplexer

This block picks eight interrupt sources out of a wide bank of GPIO pad inputs and presents each one to a downstream interrupt controller. All pads are first synchronized to the block clock. Each of the eight channels then selects one pad by index and runs it through an optional glitch filter. The channel can invert the signal and then sends it out either as a level or as a single-clock edge event. Every output line is active-high. Active-low and falling-edge sources are handled by setting the channel's inversion bit, so the parent controller only ever sees high levels or rising-edge pulses.

Software configures the channels through four 32-bit registers on a simple write-strobe bus with combinational read data. The registers hold the pad selects, the mode and inversion bits, and the filter lengths. Changing a channel's configuration while it is active can produce one output event, because the output follows the new setting from the next clock.

Top module: `gpio_chmux`

## Requirements
- R1: After reset, every register reads zero and all eight `irq_out` lines are low.
- R2: The registers at byte offsets 0x00, 0x04, 0x08 and 0x0C read back the last 32-bit value written. A write to any other offset changes no register, and a read from any other offset returns zero.
- R3: Channel c takes its pad index from an 8-bit field. For c = 0..3 the field is in register 0x04, and for c = 4..7 it is in register 0x08. In both cases the field starts at bit (c mod 4)*8. The channel observes the pad with that index.
- R4: A pad index at or above `NUM_PADS` selects a constant zero. Such a channel is therefore low in level mode without inversion, and high with inversion.
- R5: When bit c of register 0x00 is clear, channel c is level-sensitive. With filtering off, `irq_out[c]` equals the selected pad, possibly inverted, three clock edges after the pad changes: two synchronizer stages and one filter stage.
- R6: Bit 16+c of register 0x00 inverts channel c before detection. With it set, a low pad drives a high level in level mode.
- R7: When bit c of register 0x00 is set, channel c is edge-triggered. A 0-to-1 transition of the adjusted signal yields exactly one clock of `irq_out[c]` high, and a 1-to-0 transition yields nothing.
- R8: In edge mode with inversion set, a falling pad edge produces the one-clock pulse and a rising pad edge produces none. Both edges are never detected together.
- R9: A 4-bit filter length N is held at bits c*4+3..c*4 of register 0x0C. For N > 0, a new value must stay on the selected input for N consecutive clocks before the filtered signal takes it. An input change that lasts fewer than N clocks is dropped. N = 0 disables the filter.
- R10: Channels are independent. Two channels that select the same pad, one in level mode and one in edge mode, both respond in the same clock.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | NUM_PADS | Asynchronous GPIO pad levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 8 | Active-high interrupt lines to the parent controller |

## Verification
Level detection and edge detection can land in the same clock when two channels select one pad. The bench configures one channel in level mode and another in edge mode on the same pad, toggles that pad once, and expects both outputs high three edges later. One edge after that, it expects the level channel still high and the edge channel already low. The same pattern is judged on a filtered channel, where a pulse one clock shorter than the filter length must leave the output untouched.

// File: rtl/gpio_chmux_pkg.sv
package gpio_chmux_pkg;
   localparam int NUM_CH    = 8;
   localparam int SEL_W     = 8;
   localparam int FILT_W    = 4;
   localparam int SEL_SPAN  = 1 << SEL_W;
   localparam int REG_W     = 32;

   localparam logic [7:0] OFF_MODE   = 8'h00;
   localparam logic [7:0] OFF_SEL_LO = 8'h04;
   localparam logic [7:0] OFF_SEL_HI = 8'h08;
   localparam logic [7:0] OFF_FILT   = 8'h0C;

   localparam int INV_BASE = 16;
endpackage

// File: rtl/gpio_chmux_sync.sv
module gpio_chmux_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_chmux_regs.sv
module gpio_chmux_regs
   import gpio_chmux_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic [REG_W-1:0]  mode_q,
   output logic [REG_W-1:0]  sel_lo_q,
   output logic [REG_W-1:0]  sel_hi_q,
   output logic [REG_W-1:0]  filt_q
);
   logic hit_mode, hit_lo, hit_hi, hit_filt, mapped;

   assign hit_mode = (addr == ADDR_W'(OFF_MODE));
   assign hit_lo   = (addr == ADDR_W'(OFF_SEL_LO));
   assign hit_hi   = (addr == ADDR_W'(OFF_SEL_HI));
   assign hit_filt = (addr == ADDR_W'(OFF_FILT));
   assign mapped   = hit_mode | hit_lo | hit_hi | hit_filt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         sel_lo_q <= '0;
         sel_hi_q <= '0;
         filt_q   <= '0;
      end else if (wr) begin
         if (hit_mode) mode_q   <= wdata;
         if (hit_lo)   sel_lo_q <= wdata;
         if (hit_hi)   sel_hi_q <= wdata;
         if (hit_filt) filt_q   <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_mode) rdata = mode_q;
      if (hit_lo)   rdata = sel_lo_q;
      if (hit_hi)   rdata = sel_hi_q;
      if (hit_filt) rdata = filt_q;
   end

   // R2: unmapped writes leave every register untouched
   assert_unmapped_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !mapped) |=> $stable({mode_q, sel_lo_q, sel_hi_q, filt_q}));

   // R2: unmapped reads return zero
   assert_unmapped_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (rdata == '0));
endmodule

// File: rtl/gpio_chmux_chan.sv
module gpio_chmux_chan
   import gpio_chmux_pkg::*;
#(
   parameter int NUM_PADS = 160
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEL_SPAN-1:0] pads_wide,
   input  logic [SEL_W-1:0]    sel,
   input  logic [FILT_W-1:0]   filt_n,
   input  logic                edge_en,
   input  logic                inv_en,
   output logic                irq_o
);
   logic              sel_in;
   logic              filt_q;
   logic [FILT_W-1:0] cnt;
   logic              pol, pol_d;

   assign sel_in = pads_wide[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         cnt    <= '0;
         pol_d  <= 1'b0;
      end else begin
         pol_d <= pol;
         if (filt_n == '0) begin
            filt_q <= sel_in;
            cnt    <= '0;
         end else if (sel_in == filt_q) begin
            cnt <= '0;
         end else if (cnt + 1'b1 == filt_n) begin
            filt_q <= sel_in;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign pol   = filt_q ^ inv_en;
   assign irq_o = edge_en ? (pol & ~pol_d) : pol;

   // R4: out-of-range pad index sees constant zero
   assert_oob_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel) >= NUM_PADS) |-> !sel_in);

   // R7: an edge event lasts exactly one clock
   assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_en && irq_o) |=> (!irq_o || !edge_en));

   // R5: unfiltered level channel tracks its input one edge later
   assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_en && filt_n == '0) |=>
         ((irq_o == ($past(sel_in) ^ inv_en)) || !$stable({edge_en, inv_en, filt_n})));

   // R9: the filtered value only takes a value the input held
   assert_filter_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q != $past(filt_q)) |-> ($past(sel_in) == filt_q));
endmodule

// File: rtl/gpio_chmux.sv
module gpio_chmux
   import gpio_chmux_pkg::*;
#(
   parameter int NUM_PADS    = 160,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PADS-1:0] pad_in,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [REG_W-1:0]    bus_wdata,
   output logic [REG_W-1:0]    bus_rdata,
   output logic [NUM_CH-1:0]   irq_out
);
   localparam int PER_REG = REG_W / SEL_W;

   initial begin
      assert (NUM_PADS >= 1 && NUM_PADS <= SEL_SPAN)
         else $error("NUM_PADS must be 1..%0d", SEL_SPAN);
      assert (ADDR_W >= 4)
         else $error("ADDR_W too narrow for the register map");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PADS-1:0] pads_sync;
   logic [SEL_SPAN-1:0] pads_wide;
   logic [REG_W-1:0]    mode_q, sel_lo_q, sel_hi_q, filt_q;

   gpio_chmux_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pads_sync));

   generate
      if (NUM_PADS < SEL_SPAN) begin : g_pad_ext
         assign pads_wide = {{(SEL_SPAN-NUM_PADS){1'b0}}, pads_sync};
      end else begin : g_pad_full
         assign pads_wide = pads_sync;
      end
   endgenerate

   gpio_chmux_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .mode_q(mode_q),
      .sel_lo_q(sel_lo_q), .sel_hi_q(sel_hi_q), .filt_q(filt_q));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [SEL_W-1:0] sel_c;
         if (c < PER_REG) begin : g_lo
            assign sel_c = sel_lo_q[(c % PER_REG)*SEL_W +: SEL_W];
         end else begin : g_hi
            assign sel_c = sel_hi_q[(c % PER_REG)*SEL_W +: SEL_W];
         end
         gpio_chmux_chan #(.NUM_PADS(NUM_PADS)) u_chan (
            .clk(clk), .rst_n(rst_n), .pads_wide(pads_wide), .sel(sel_c),
            .filt_n(filt_q[c*FILT_W +: FILT_W]),
            .edge_en(mode_q[c]), .inv_en(mode_q[INV_BASE + c]),
            .irq_o(irq_out[c]));
      end
   endgenerate

   // R1: no interrupt line is high in the first cycle after reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (irq_out == '0));
endmodule

// File: tb/gpio_chmux_tb_top.sv
module gpio_chmux_tb_top;
   localparam int NP = 160;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pad_in = '0;
   logic          bus_wr = 1'b0;
   logic [4:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [7:0]    irq_out;

   gpio_chmux #(.NUM_PADS(NP), .ADDR_W(5), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out));

   always #10 clk = ~clk;

   int cyc = 0;
   always_ff @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      int    due;
      int    ch;
      logic  val;
      string tag;
   } exp_t;
   exp_t sbq[$];
   exp_t keep[$];

   logic [31:0] r_mode, r_lo, r_hi, r_filt;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic cfg();
      wr(5'h00, r_mode);
      wr(5'h04, r_lo);
      wr(5'h08, r_hi);
      wr(5'h0C, r_filt);
   endtask

   task automatic expect_irq(int dly, int ch, logic v, string tag);
      exp_t e;
      e.due = cyc + dly; e.ch = ch; e.val = v; e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic pad_set(int idx, logic v);
      @(negedge clk);
      pad_in[idx] = v;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops due expectations away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         keep = {};
         foreach (sbq[i]) begin
            if (sbq[i].due <= cyc) chk(sbq[i].tag, {31'b0, irq_out[sbq[i].ch]}, {31'b0, sbq[i].val});
            else keep.push_back(sbq[i]);
         end
         sbq = keep;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      r_mode = '0; r_lo = '0; r_hi = '0; r_filt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk); #2;
      chk("R1 irq_out after reset", {24'b0, irq_out}, 32'h0);
      rd_chk(5'h00, 32'h0, "R1 mode reg reset");
      rd_chk(5'h04, 32'h0, "R1 sel_lo reg reset");
      rd_chk(5'h08, 32'h0, "R1 sel_hi reg reset");
      rd_chk(5'h0C, 32'h0, "R1 filt reg reset");

      // R2 readback and unmapped offsets
      wr(5'h00, 32'h1234_0000); wr(5'h04, 32'hDEAD_BEEF);
      wr(5'h08, 32'h0BAD_F00D); wr(5'h0C, 32'h5A5A_A5A5);
      wr(5'h10, 32'hFFFF_FFFF); wr(5'h14, 32'hFFFF_FFFF);
      rd_chk(5'h00, 32'h1234_0000, "R2 mode readback");
      rd_chk(5'h04, 32'hDEAD_BEEF, "R2 sel_lo readback");
      rd_chk(5'h08, 32'h0BAD_F00D, "R2 sel_hi readback");
      rd_chk(5'h0C, 32'h5A5A_A5A5, "R2 filt readback");
      rd_chk(5'h10, 32'h0, "R2 unmapped read zero");
      rd_chk(5'h1C, 32'h0, "R2 unmapped read zero high");
      cfg();
      idle(4);

      // R3 / R5 level mode: ch0 pad 5, ch5 pad 37
      r_lo = 32'h0000_0005; r_hi = 32'h0000_2500; cfg(); idle(4);
      pad_set(5, 1'b1);
      expect_irq(2, 0, 1'b0, "R5 ch0 still low before latency");
      expect_irq(3, 0, 1'b1, "R5 ch0 level high after 3 edges");
      expect_irq(3, 5, 1'b0, "R3 ch5 ignores pad 5");
      idle(5);
      pad_set(37, 1'b1);
      expect_irq(3, 5, 1'b1, "R3 ch5 follows pad 37");
      idle(5);
      pad_set(5, 1'b0);
      expect_irq(3, 0, 1'b0, "R5 ch0 level returns low");
      expect_irq(3, 5, 1'b1, "R3 ch5 unaffected by pad 5");
      idle(5);
      pad_set(37, 1'b0);
      idle(5);

      // R4 out-of-range pad index on ch7
      r_hi = 32'hC800_0000; cfg();
      @(negedge clk); pad_in = '1;
      idle(6);
      expect_irq(0, 7, 1'b0, "R4 index 200 reads zero");
      idle(2);
      r_mode = 32'h0080_0000; cfg(); idle(4);
      expect_irq(0, 7, 1'b1, "R4 index 200 inverted reads one");
      idle(2);
      @(negedge clk); pad_in = '0;
      r_mode = '0; cfg(); idle(5);

      // R6 inverted level on ch1 pad 9
      r_lo = 32'h0000_0900; r_mode = 32'h0002_0000; cfg(); idle(4);
      expect_irq(0, 1, 1'b1, "R6 low pad gives high level");
      idle(2);
      pad_set(9, 1'b1);
      expect_irq(2, 1, 1'b1, "R6 still high before latency");
      expect_irq(3, 1, 1'b0, "R6 high pad gives low level");
      idle(5);
      pad_set(9, 1'b0);
      idle(5);

      // R7 rising edge on ch2 pad 12
      r_lo = 32'h000C_0000; r_mode = 32'h0000_0004; cfg(); idle(4);
      pad_set(12, 1'b1);
      expect_irq(2, 2, 1'b0, "R7 no pulse before latency");
      expect_irq(3, 2, 1'b1, "R7 pulse on rise");
      expect_irq(4, 2, 1'b0, "R7 pulse lasts one clock");
      idle(6);
      pad_set(12, 1'b0);
      expect_irq(3, 2, 1'b0, "R7 no pulse on fall");
      expect_irq(4, 2, 1'b0, "R7 no pulse after fall");
      idle(6);

      // R8 falling edge via inversion on ch3 pad 14
      r_lo = 32'h0E00_0000; r_mode = 32'h0008_0008; cfg(); idle(6);
      pad_set(14, 1'b1);
      expect_irq(3, 3, 1'b0, "R8 no pulse on rise");
      expect_irq(4, 3, 1'b0, "R8 no pulse after rise");
      idle(6);
      pad_set(14, 1'b0);
      expect_irq(3, 3, 1'b1, "R8 pulse on fall");
      expect_irq(4, 3, 1'b0, "R8 fall pulse lasts one clock");
      idle(6);

      // R9 filter length 3 on ch4 pad 20
      r_mode = '0; r_hi = 32'h0000_0014; r_filt = 32'h0003_0000; cfg(); idle(4);
      pad_set(20, 1'b1);
      idle(1);
      pad_set(20, 1'b0);
      for (int k = 2; k <= 7; k++) expect_irq(k, 4, 1'b0, "R9 short pulse dropped");
      idle(9);
      pad_set(20, 1'b1);
      expect_irq(4, 4, 1'b0, "R9 not yet passed at N-1");
      expect_irq(5, 4, 1'b1, "R9 passes after N clocks");
      idle(8);
      pad_set(20, 1'b0);
      expect_irq(4, 4, 1'b1, "R9 release held at N-1");
      expect_irq(5, 4, 1'b0, "R9 release passes after N");
      idle(8);

      // R10 shared pad 30: ch0 level, ch6 edge
      r_filt = '0; r_mode = 32'h0000_0040;
      r_lo = 32'h0000_001E; r_hi = 32'h001E_0000; cfg(); idle(4);
      pad_set(30, 1'b1);
      expect_irq(3, 0, 1'b1, "R10 level channel fires");
      expect_irq(3, 6, 1'b1, "R10 edge channel fires same clock");
      expect_irq(4, 0, 1'b1, "R10 level channel stays high");
      expect_irq(4, 6, 1'b0, "R10 edge channel pulse ends");
      idle(6);
      pad_set(30, 1'b0);
      expect_irq(3, 0, 1'b0, "R10 level channel drops");
      expect_irq(3, 6, 1'b0, "R10 edge channel quiet on fall");
      idle(6);

      while (sbq.size() != 0) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule